// File: doc/BRIEF.md
# Shared-Period Three-Channel PWM Timer

An up-counting timer whose counter produces one common PWM period for several output channels. A period-compare value `m` sets the period to m+1 counts: the counter runs 0, 1, ..., m and returns to 0 on the tick after it reaches m. Each channel has its own duty-compare value `n`. A channel sits in its inactive phase while the counter covers 0..n and in its active phase while it covers n+1..m. Each channel chooses which pin level counts as active, and each has an initial phase that holds until the first compare event after a start.

The counter advances on one of two tick sources. One is an internal clock-enable input. The other is a rising edge on an external clock pin, which passes through a synchronizer first. Software starts and halts counting with a level start control. An optional mode halts the counter by itself when it reaches the period value. A cutoff input pulls every enabled output to its inactive level. Sticky flags record compare matches and counter overflow, and the counter can be read and written at any time.

Top module: `pwm3_timer`

## Requirements
- R1: While running, the counter increments by one on each accepted tick. With `ext_sel_i`=0 the tick is `int_tick_i`. With `ext_sel_i`=1 the tick comes from the external pin, and `int_tick_i` has no effect.
- R2: With `ext_sel_i`=1, each rising edge of `ext_clk_i` adds exactly one count, after a two-flop synchronizer and edge detector. Each level of the pin must be held for at least two clock cycles.
- R3: With period value m, the counter visits 0..m and reaches 0 on the tick after it equals m, so one PWM period is m+1 ticks.
- R4: With duty value n < m, a channel is inactive for n+1 ticks and active for m−n ticks of each period. A channel with n ≥ m leaves the active phase at the first period wrap and never re-enters it.
- R5: `pol_i[k]`=1 makes the active level high and `pol_i[k]`=0 makes it low. Pin k shows the phase, with this polarity applied, through one register.
- R6: While the counter is stopped and has not advanced since reset or since the last counter write, channel k's phase follows `init_i[k]` (1 = active).
- R7: A 0→1 change of `start_i` starts counting, and `start_i`=0 halts it. While halted, the counter value and all pins keep their values.
- R8: With `stop_at_match_i`=1, the counter halts when it reaches m and holds m. The pins keep their levels. Counting resumes only after `start_i` goes low and high again, and the next tick then wraps the counter to 0.
- R9: `flag_o` is sticky. Bit 0 is set when a tick brings the counter to the period value. Bits 1..3 are set when a tick brings it to the duty values of channels 0..2. Bit 4 is set when the counter rolls from all-ones to 0. A 1 on `flag_clr_i[i]` clears bit i, but a new set in the same cycle wins.
- R10: `cnt_we_i`=1 loads `cnt_wdata_i` into the counter at the next edge, takes priority over any tick, and sets no flag. `cnt_o` always shows the counter. After reset the counter and the flags are 0.
- R11: When `pwm_en_i[k]`=0, pin k is driven 0.
- R12: While `cutoff_i`=1, every enabled pin goes to its inactive level (the inverse of `pol_i[k]`) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Count start level; a rising change starts counting |
| stop_at_match_i | input | 1 | 1 = halt on reaching the period value |
| ext_sel_i | input | 1 | Tick source: 0 internal enable, 1 external pin |
| int_tick_i | input | 1 | Internal count enable |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CW | Counter write value |
| cnt_o | output | CW | Current counter value |
| period_i | input | CW | Period compare value m |
| duty_i | input | NCH*CW | Duty compare values, channel k in bits k*CW +: CW |
| pwm_en_i | input | NCH | Per-channel PWM output enable |
| pol_i | input | NCH | Per-channel active level (1 = high) |
| init_i | input | NCH | Per-channel initial phase (1 = active) |
| cutoff_i | input | 1 | Forced cutoff of enabled outputs |
| flag_clr_i | input | NCH+2 | Write-one-to-clear for flags |
| flag_o | output | NCH+2 | Sticky match and overflow flags |
| pwm_o | output | NCH | PWM output pins |

## Verification
Some properties are checked on every cycle by the assertions. These are the counter's single-step increment, its wrap to zero after the period value, its hold while halted, and the halt on the period match in stop mode. They also cover flag stickiness and the overflow flag, the low level of disabled pins, and the inactive level under cutoff. Other behaviour can only be shown by the directed scenarios, because it spans a whole period or depends on a sequence of events. That includes the duty ratios and the period length seen at the pins, active-low polarity, the initial phase before the first event, counting from the synchronized external pin, restart after a stop-at-match halt, and the full set of flags after a run.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;

  // flag vector layout: period match, one bit per channel, overflow last
  localparam int FLG_PERIOD = 0;

  function automatic int flg_chan(input int k);
    return k + 1;
  endfunction

  function automatic int flg_ovf(input int nch);
    return nch + 1;
  endfunction

endpackage

// File: rtl/pwm3_tick_src.sv
module pwm3_tick_src #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_sel_i,
  input  logic int_tick_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  import pwm3_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              ext_rise;
  tick_src_e         src;

  // synchronizer chain followed by one delay flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= ext_clk_i;
      for (int i = 1; i < STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ext_rise = sync_q[STAGES-1] & ~last_q;
  assign src      = tick_src_e'(src_sel_i);

  always_comb begin
    unique case (src)
      SRC_EXTERNAL: tick_o = ext_rise;
      default:      tick_o = int_tick_i;
    endcase
  end

endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          stop_at_match_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] nxt_o,
  output logic          run_q,
  output logic          adv_o,
  output logic          wrap_o,
  output logic          ovf_o,
  output logic          fresh_q
);

  logic start_d;
  logic at_period;
  logic at_max;
  logic stop_hit;

  assign at_period = (cnt_q == period_i);
  assign at_max    = &cnt_q;
  assign adv_o     = run_q & tick_i & ~we_i;
  assign wrap_o    = adv_o & at_period;
  assign ovf_o     = adv_o & at_max & ~at_period;

  always_comb begin
    if (at_period) nxt_o = '0;
    else           nxt_o = cnt_q + 1'b1;
  end

  assign stop_hit = adv_o & stop_at_match_i & (nxt_o == period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      start_d <= start_i;
      if (!start_i)            run_q <= 1'b0;
      else if (!start_d)       run_q <= 1'b1;
      else if (stop_hit)       run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (we_i) begin
      cnt_q   <= wdata_i;
      fresh_q <= 1'b1;
    end else if (adv_o) begin
      cnt_q   <= nxt_o;
      fresh_q <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !we_i && cnt_q != period_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !we_i && cnt_q == period_i) |=> (cnt_q == '0)); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !we_i) |=> (cnt_q == $past(cnt_q))); // R7

  AST_STOP_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (stop_at_match_i && start_i && start_d && adv_o && nxt_o == period_i)
      |=> (!run_q && cnt_q == period_i)); // R8

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (cnt_q == $past(wdata_i))); // R10

endmodule

// File: rtl/pwm3_flags.sv
module pwm3_flags #(
  parameter int CW  = 16,
  parameter int NCH = 3,
  localparam int NF = NCH + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              ovf_i,
  input  logic [CW-1:0]     nxt_i,
  input  logic [CW-1:0]     period_i,
  input  logic [NCH*CW-1:0] duty_i,
  input  logic [NF-1:0]     clr_i,
  output logic [NF-1:0]     flags_q
);
  import pwm3_pkg::*;

  logic [NF-1:0] set_v;

  always_comb begin
    set_v = '0;
    set_v[FLG_PERIOD] = adv_i && (nxt_i == period_i);
    for (int k = 0; k < NCH; k++) begin
      set_v[flg_chan(k)] = adv_i && (nxt_i == duty_i[k*CW +: CW]);
    end
    set_v[flg_ovf(NCH)] = ovf_i;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_i) | set_v;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(flags_q & ~clr_i)) |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i))); // R9

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> flags_q[flg_ovf(NCH)]); // R9

endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic          run_i,
  input  logic          fresh_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  input  logic          en_i,
  input  logic          pol_i,
  input  logic          init_i,
  input  logic          cutoff_i,
  output logic          pin_q
);

  logic act_q;
  logic duty_reach;
  logic pin_d;

  // leaving the duty value starts the active phase, wrap ends it
  assign duty_reach = adv_i && (cnt_i == duty_i) && (duty_i < period_i);

  always_ff @(posedge clk) begin
    if (rst)                  act_q <= 1'b0;
    else if (!run_i && fresh_i) act_q <= init_i;
    else if (wrap_i)          act_q <= 1'b0;
    else if (duty_reach)      act_q <= 1'b1;
  end

  always_comb begin
    if (!en_i)         pin_d = 1'b0;
    else if (cutoff_i) pin_d = ~pol_i;
    else               pin_d = act_q ? pol_i : ~pol_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> !act_q); // R4

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pin_q); // R11

  AST_CUTOFF_SAFE: assert property (@(posedge clk) disable iff (rst)
    (en_i && cutoff_i) |=> (pin_q == !$past(pol_i))); // R12

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
  parameter int CW          = 16,
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NF         = NCH + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_at_match_i,
  input  logic              ext_sel_i,
  input  logic              int_tick_i,
  input  logic              ext_clk_i,
  input  logic              cnt_we_i,
  input  logic [CW-1:0]     cnt_wdata_i,
  output logic [CW-1:0]     cnt_o,
  input  logic [CW-1:0]     period_i,
  input  logic [NCH*CW-1:0] duty_i,
  input  logic [NCH-1:0]    pwm_en_i,
  input  logic [NCH-1:0]    pol_i,
  input  logic [NCH-1:0]    init_i,
  input  logic              cutoff_i,
  input  logic [NF-1:0]     flag_clr_i,
  output logic [NF-1:0]     flag_o,
  output logic [NCH-1:0]    pwm_o
);

  logic          tick;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt;
  logic          run_q;
  logic          adv;
  logic          wrap;
  logic          ovf;
  logic          fresh_q;

  pwm3_tick_src #(.STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst        (rst),
    .src_sel_i  (ext_sel_i),
    .int_tick_i (int_tick_i),
    .ext_clk_i  (ext_clk_i),
    .tick_o     (tick)
  );

  pwm3_counter #(.CW(CW)) u_cnt (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick),
    .start_i         (start_i),
    .stop_at_match_i (stop_at_match_i),
    .we_i            (cnt_we_i),
    .wdata_i         (cnt_wdata_i),
    .period_i        (period_i),
    .cnt_q           (cnt_q),
    .nxt_o           (nxt),
    .run_q           (run_q),
    .adv_o           (adv),
    .wrap_o          (wrap),
    .ovf_o           (ovf),
    .fresh_q         (fresh_q)
  );

  pwm3_flags #(.CW(CW), .NCH(NCH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .ovf_i    (ovf),
    .nxt_i    (nxt),
    .period_i (period_i),
    .duty_i   (duty_i),
    .clr_i    (flag_clr_i),
    .flags_q  (flag_o)
  );

  for (genvar gk = 0; gk < NCH; gk++) begin : g_chan
    pwm3_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .adv_i    (adv),
      .wrap_i   (wrap),
      .run_i    (run_q),
      .fresh_i  (fresh_q),
      .cnt_i    (cnt_q),
      .period_i (period_i),
      .duty_i   (duty_i[gk*CW +: CW]),
      .en_i     (pwm_en_i[gk]),
      .pol_i    (pol_i[gk]),
      .init_i   (init_i[gk]),
      .cutoff_i (cutoff_i),
      .pin_q    (pwm_o[gk])
    );
  end

  assign cnt_o = cnt_q;

endmodule

// File: tb/tb_pwm3_timer.sv
`timescale 1ns/1ps
module tb_pwm3_timer;

  localparam int CW  = 16;
  localparam int NCH = 3;
  localparam int NF  = NCH + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              stop_at_match_i = 1'b0;
  logic              ext_sel_i = 1'b0;
  logic              int_tick_i = 1'b0;
  logic              ext_clk_i = 1'b0;
  logic              cnt_we_i = 1'b0;
  logic [CW-1:0]     cnt_wdata_i = '0;
  logic [CW-1:0]     cnt_o;
  logic [CW-1:0]     period_i = 16'd9;
  logic [NCH*CW-1:0] duty_i = {16'd12, 16'd6, 16'd3};
  logic [NCH-1:0]    pwm_en_i = 3'b111;
  logic [NCH-1:0]    pol_i = 3'b111;
  logic [NCH-1:0]    init_i = 3'b000;
  logic              cutoff_i = 1'b0;
  logic [NF-1:0]     flag_clr_i = '0;
  logic [NF-1:0]     flag_o;
  logic [NCH-1:0]    pwm_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  pwm3_timer #(.CW(CW), .NCH(NCH)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_at_match_i(stop_at_match_i),
    .ext_sel_i(ext_sel_i), .int_tick_i(int_tick_i), .ext_clk_i(ext_clk_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o),
    .period_i(period_i), .duty_i(duty_i), .pwm_en_i(pwm_en_i), .pol_i(pol_i),
    .init_i(init_i), .cutoff_i(cutoff_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cnt(input logic [CW-1:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    step(1);
    cnt_we_i = 1'b0;
  endtask

  task automatic halt();
    start_i = 1'b0;
    step(2);
  endtask

  task automatic clear_flags();
    flag_clr_i = '1;
    step(1);
    flag_clr_i = '0;
  endtask

  task automatic t_reset();
    chk("R10", "counter after reset", cnt_o, 0);
    chk("R10", "flags after reset", flag_o, 0);
    chk("R6", "pins with init 0", pwm_o, 0);
  endtask

  task automatic t_count_and_halt();
    logic [CW-1:0] c0;
    logic [NCH-1:0] p0;
    period_i = 16'd1000;
    int_tick_i = 1'b1;
    write_cnt(16'd0);
    start_i = 1'b1;
    step(3);
    c0 = cnt_o;
    step(5);
    chk("R1", "increments per tick", cnt_o, c0 + 5);
    int_tick_i = 1'b0;
    c0 = cnt_o;
    step(4);
    chk("R1", "no tick no count", cnt_o, c0);
    int_tick_i = 1'b1;
    halt();
    c0 = cnt_o; p0 = pwm_o;
    step(6);
    chk("R7", "count holds when halted", cnt_o, c0);
    chk("R7", "pins hold when halted", pwm_o, p0);
  endtask

  task automatic t_external();
    logic [CW-1:0] c0;
    ext_sel_i = 1'b1;
    int_tick_i = 1'b1;
    write_cnt(16'd0);
    start_i = 1'b1;
    step(3);
    c0 = cnt_o;
    chk("R1", "internal tick ignored in external mode", c0, 0);
    for (int i = 0; i < 5; i++) begin
      ext_clk_i = 1'b1; step(3);
      ext_clk_i = 1'b0; step(3);
    end
    step(4);
    chk("R2", "one count per external edge", cnt_o, c0 + 5);
    halt();
    ext_sel_i = 1'b0;
  endtask

  task automatic t_period_duty();
    int act_cnt [NCH];
    int bad_seq, max_c, rises;
    logic [CW-1:0] prev;
    logic prev_b;
    period_i = 16'd9;
    duty_i = {16'd12, 16'd6, 16'd3};
    pol_i = 3'b101;
    init_i = 3'b000;
    int_tick_i = 1'b1;
    write_cnt(16'd0);
    start_i = 1'b1;
    step(30);
    for (int k = 0; k < NCH; k++) act_cnt[k] = 0;
    bad_seq = 0; max_c = 0; rises = 0;
    prev = cnt_o; prev_b = pwm_o[0];
    for (int s = 0; s < 30; s++) begin
      step(1);
      if (!((cnt_o == prev + 1'b1) || (prev == 16'd9 && cnt_o == 0))) bad_seq++;
      if (int'(cnt_o) > max_c) max_c = int'(cnt_o);
      if (pwm_o[0] && !prev_b) rises++;
      prev = cnt_o; prev_b = pwm_o[0];
      if (s < 10) begin
        for (int k = 0; k < NCH; k++) if (pwm_o[k] == pol_i[k]) act_cnt[k]++;
      end
    end
    chk("R3", "count sequence violations", bad_seq, 0);
    chk("R3", "highest count", max_c, 9);
    chk("R3", "period starts in 30 ticks", rises, 3);
    chk("R4", "ch0 active ticks per period", act_cnt[0], 6);
    chk("R5", "ch1 active-low ticks per period", act_cnt[1], 3);
    chk("R4", "ch2 duty above period never active", act_cnt[2], 0);
    halt();
    pol_i = 3'b111;
  endtask

  task automatic t_initial();
    init_i = 3'b011;
    write_cnt(16'd0);
    step(3);
    chk("R6", "pins follow initial phase 011", pwm_o, 3'b011);
    init_i = 3'b100;
    step(3);
    chk("R6", "pins follow initial phase 100", pwm_o, 3'b100);
    start_i = 1'b1;
    step(3);
    chk("R6", "initial phase held until first event", pwm_o, 3'b100);
    step(12);
    chk("R4", "duty above period leaves active at wrap", pwm_o[2], 0);
    halt();
    init_i = 3'b000;
  endtask

  task automatic t_stop_at_match();
    stop_at_match_i = 1'b1;
    write_cnt(16'd0);
    clear_flags();
    start_i = 1'b1;
    step(20);
    chk("R8", "halted at period value", cnt_o, 9);
    chk("R8", "pins after stop", pwm_o, 3'b011);
    chk("R9", "period match flag", flag_o[0], 1);
    step(5);
    chk("R8", "stays at period value", cnt_o, 9);
    start_i = 1'b0;
    stop_at_match_i = 1'b0;
    step(1);
    start_i = 1'b1;
    step(3);
    chk("R8", "restart wraps to zero then counts", cnt_o, 1);
    halt();
  endtask

  task automatic t_flags();
    write_cnt(16'd0);
    clear_flags();
    start_i = 1'b1;
    step(25);
    halt();
    chk("R9", "flags after free run", flag_o, 5'b00111);
    clear_flags();
    chk("R9", "flags cleared", flag_o, 0);
    write_cnt(16'hFFFD);
    chk("R10", "write sets no flag", flag_o, 0);
    start_i = 1'b1;
    step(6);
    chk("R10", "count after rollover", cnt_o, 2);
    chk("R9", "overflow flag", flag_o[4], 1);
    chk("R9", "no period flag before reaching m", flag_o[0], 0);
    halt();
  endtask

  task automatic t_write_running();
    period_i = 16'd1000;
    write_cnt(16'd0);
    start_i = 1'b1;
    step(4);
    write_cnt(16'd500);
    chk("R10", "write wins over tick", cnt_o, 500);
    step(1);
    chk("R10", "counts on after write", cnt_o, 501);
    halt();
    period_i = 16'd9;
  endtask

  task automatic t_enable_cutoff();
    int bad;
    write_cnt(16'd0);
    pol_i = 3'b110;
    pwm_en_i = 3'b101;
    start_i = 1'b1;
    cutoff_i = 1'b1;
    step(2);
    bad = 0;
    for (int s = 0; s < 12; s++) begin
      if (pwm_o != 3'b001) bad++;
      step(1);
    end
    chk("R12", "cutoff holds inactive levels", bad, 0);
    chk("R12", "pins under cutoff", pwm_o, 3'b001);
    cutoff_i = 1'b0;
    pwm_en_i = 3'b000;
    step(2);
    bad = 0;
    for (int s = 0; s < 12; s++) begin
      if (pwm_o != 3'b000) bad++;
      step(1);
    end
    chk("R11", "disabled pins stay low", bad, 0);
    halt();
    pwm_en_i = 3'b111;
    pol_i = 3'b111;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(3);
    t_reset();
    t_count_and_halt();
    t_external();
    t_period_duty();
    t_initial();
    t_stop_at_match();
    t_flags();
    t_write_running();
    t_enable_cutoff();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule